// File: doc/BRIEF.md
# Converter Sample Formatter with Range Clamp

This block sits behind the capture flops of one channel of a dual-channel pipelined converter. Each valid cycle it takes a 13-bit parallel word and the converter's out-of-range pin. It turns the word into a signed, sign-extended 13-bit sample and registers it with one cycle of latency. It also raises separate over and under flags. The input coding is chosen by a format select: offset binary or two's complement. Offset binary is converted by inverting the top bit, so mid-scale (4096) becomes zero.

Three output configurations are supported:
- Full 13-bit: every bit carries data.
- 12-bit: the least significant bit is discarded.
- Reduced-range 12-bit: the low twelve bits form a two's-complement word that wraps past full scale. The two top bits reveal that wrap, and the sample is saturated.

Reduced range is only meaningful with two's-complement input. Any other combination is reported as a configuration error, and the block then passes zero data.

Top module: `adc_sample_fmt`

## Requirements
- R1: After reset, out_sample, out_vld, out_over, out_under and cfg_err are all 0.
- R2: A sample with in_vld high appears on the outputs on the next rising edge, with out_vld high. A cycle with in_vld low gives out_vld low and leaves out_sample and the flags unchanged.
- R3: Full mode (mode=0): out_sample is the input word as two's complement. With fmt_twos=0 the top bit is inverted first, so 0x1000 gives 0 and 0x1005 gives 5.
- R4: Full mode overrange: a normalised word of 0x0FFF (offset-binary all ones) sets out_over with out_sample=0x0FFF. A normalised word of 0x1000 (offset-binary all zeros) sets out_under with out_sample=0x1000.
- R5: 12-bit mode (mode=1): out_sample is normalised bits 12..1, sign-extended to 13 bits.
- R6: 12-bit mode flags only when all 13 normalised bits are at full scale. 0x0FFF gives over with 0x07FF, and 0x1000 gives under with 0x1800. A word whose bits 12..1 are at full scale but whose bit 0 differs raises no flag.
- R7: Reduced mode (mode=2, fmt_twos=1): out_sample is input bits 11..0 sign-extended from bit 11.
- R8: Reduced mode saturation: bit12=0 with bit11=1 sets out_over with out_sample=0x07FF. Bit12=1 with bit11=0 sets out_under with out_sample=0x1800.
- R9: In full and 12-bit modes, in_orng=1 clamps the sample to the mode's positive limit with out_over when the normalised sign bit is 0. It clamps to the negative limit with out_under when the sign bit is 1. In reduced mode in_orng has no effect.
- R10: mode=2 with fmt_twos=0, or mode=3, registers cfg_err=1 on every clock edge. A valid sample in that configuration gives out_sample=0 with both flags 0.
- R11: out_over and out_under are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Captured word is valid this cycle |
| in_data | input | 13 | Captured converter word |
| in_orng | input | 1 | Converter out-of-range pin |
| fmt_twos | input | 1 | 0 offset binary, 1 two's complement |
| mode | input | 2 | 0 full, 1 twelve-bit, 2 reduced range, 3 reserved |
| out_sample | output | 13 | Signed, sign-extended sample |
| out_vld | output | 1 | out_sample updated this cycle |
| out_over | output | 1 | Sample clamped at positive limit |
| out_under | output | 1 | Sample clamped at negative limit |
| cfg_err | output | 1 | Invalid mode and format combination |

## Verification
The assertions assume that mode and fmt_twos are static configuration. The reduced-range saturation check assumes they do not change in the cycle after a valid sample. The bench changes configuration only in cycles where in_vld is low, and lets one idle edge pass before the next valid word. in_vld and in_data are assumed known whenever reset is released, so the bench drives them low from time zero.

// File: rtl/adc_sample_fmt.sv
module adc_sample_fmt #(
  parameter int DW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [DW-1:0] in_data,
  input  logic          in_orng,
  input  logic          fmt_twos,
  input  logic [1:0]    mode,
  output logic [DW-1:0] out_sample,
  output logic          out_vld,
  output logic          out_over,
  output logic          out_under,
  output logic          cfg_err
);
  localparam logic [1:0] M_FULL = 2'd0;
  localparam logic [1:0] M_HALF = 2'd1;
  localparam logic [1:0] M_RED  = 2'd2;
  localparam logic [DW-1:0] POS_FULL = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] NEG_FULL = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] POS_HALF = {2'b00, {(DW-2){1'b1}}};
  localparam logic [DW-1:0] NEG_HALF = {2'b11, {(DW-2){1'b0}}};

  logic [DW-1:0] norm, nxt_sample;
  logic          at_pos, at_neg, pin_pos, pin_neg, red_ov, red_un, bad_cfg;
  logic          nxt_over, nxt_under;

  assign norm    = {in_data[DW-1] ^ ~fmt_twos, in_data[DW-2:0]};
  assign at_pos  = (norm == POS_FULL);
  assign at_neg  = (norm == NEG_FULL);
  assign pin_pos = in_orng & ~norm[DW-1];
  assign pin_neg = in_orng &  norm[DW-1];
  assign red_ov  = ~in_data[DW-1] &  in_data[DW-2];
  assign red_un  =  in_data[DW-1] & ~in_data[DW-2];
  assign bad_cfg = (mode == 2'd3) || (mode == M_RED && !fmt_twos);

  always_comb begin
    nxt_sample = '0;
    nxt_over   = 1'b0;
    nxt_under  = 1'b0;
    if (!bad_cfg) begin
      case (mode)
        M_FULL: begin
          nxt_over   = at_pos | pin_pos;
          nxt_under  = at_neg | pin_neg;
          nxt_sample = nxt_over ? POS_FULL : nxt_under ? NEG_FULL : norm;
        end
        M_HALF: begin
          nxt_over   = at_pos | pin_pos;
          nxt_under  = at_neg | pin_neg;
          nxt_sample = nxt_over ? POS_HALF : nxt_under ? NEG_HALF
                                : {norm[DW-1], norm[DW-1:1]};
        end
        default: begin
          nxt_over   = red_ov;
          nxt_under  = red_un;
          nxt_sample = red_ov ? POS_HALF : red_un ? NEG_HALF
                              : {in_data[DW-2], in_data[DW-2:0]};
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_sample <= '0;
      out_vld    <= 1'b0;
      out_over   <= 1'b0;
      out_under  <= 1'b0;
      cfg_err    <= 1'b0;
    end else begin
      out_vld <= in_vld;
      cfg_err <= bad_cfg;
      if (in_vld) begin
        out_sample <= nxt_sample;
        out_over   <= nxt_over;
        out_under  <= nxt_under;
      end
    end
  end

  // R11
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_over && out_under));

  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> (!out_vld && $stable(out_sample) && $stable(out_over) && $stable(out_under)));

  // R10
  cfg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && cfg_err) |-> (out_sample == '0 && !out_over && !out_under));

  // R8
  red_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && mode == M_RED && fmt_twos && !in_data[DW-1] && in_data[DW-2])
      |=> (out_over && out_sample == POS_HALF));

  // R4
  over_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_over) |-> !out_sample[DW-1]);

  // R4
  under_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_under) |-> out_sample[DW-1]);
endmodule

// File: tb/test_adc_sample_fmt.sv
module test_adc_sample_fmt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic [12:0] in_data = '0;
  logic        in_orng = 1'b0;
  logic        fmt_twos = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [12:0] out_sample;
  logic        out_vld, out_over, out_under, cfg_err;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  adc_sample_fmt i_adc_sample_fmt (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data),
    .in_orng(in_orng), .fmt_twos(fmt_twos), .mode(mode),
    .out_sample(out_sample), .out_vld(out_vld), .out_over(out_over),
    .out_under(out_under), .cfg_err(cfg_err));

  task automatic check(string req, logic [12:0] es, logic ev, logic eo, logic eu, logic ec);
    checks++;
    if (out_sample !== es || out_vld !== ev || out_over !== eo ||
        out_under !== eu || cfg_err !== ec) begin
      fails++;
      $display("FAIL %s: got s=%h v=%b o=%b u=%b c=%b exp s=%h v=%b o=%b u=%b c=%b",
               req, out_sample, out_vld, out_over, out_under, cfg_err,
               es, ev, eo, eu, ec);
    end
  endtask

  task automatic config_set(logic [1:0] m, logic f);
    @(negedge clk);
    in_vld = 1'b0; mode = m; fmt_twos = f;
    @(negedge clk);
  endtask

  task automatic push(logic [12:0] d, logic orng);
    @(negedge clk);
    in_vld = 1'b1; in_data = d; in_orng = orng;
    @(negedge clk);
    in_vld = 1'b0; in_orng = 1'b0;
  endtask

  task automatic t_reset;
    #1; check("R1", 13'h0000, 0, 0, 0, 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_full;
    config_set(2'd0, 1'b0);
    push(13'h1000, 0); check("R3 mid", 13'h0000, 1, 0, 0, 0);
    push(13'h1005, 0); check("R3 pos", 13'h0005, 1, 0, 0, 0);
    push(13'h0FFE, 0); check("R3 neg", 13'h1FFE, 1, 0, 0, 0);
    push(13'h1FFF, 0); check("R4 over", 13'h0FFF, 1, 1, 0, 0);
    push(13'h0000, 0); check("R4 under", 13'h1000, 1, 0, 1, 0);
    config_set(2'd0, 1'b1);
    push(13'h0003, 0); check("R3 twos", 13'h0003, 1, 0, 0, 0);
    push(13'h0FFF, 0); check("R4 twos over", 13'h0FFF, 1, 1, 0, 0);
    push(13'h1000, 0); check("R4 twos under", 13'h1000, 1, 0, 1, 0);
  endtask

  task automatic t_half;
    config_set(2'd1, 1'b0);
    push(13'h1006, 0); check("R5", 13'h0003, 1, 0, 0, 0);
    push(13'h0FFC, 0); check("R5 neg", 13'h1FFE, 1, 0, 0, 0);
    push(13'h1FFF, 0); check("R6 over", 13'h07FF, 1, 1, 0, 0);
    push(13'h1FFE, 0); check("R6 lsb differs", 13'h07FF, 1, 0, 0, 0);
    push(13'h0000, 0); check("R6 under", 13'h1800, 1, 0, 1, 0);
    push(13'h0001, 0); check("R6 lsb differs neg", 13'h1800, 1, 0, 0, 0);
  endtask

  task automatic t_reduced;
    config_set(2'd2, 1'b1);
    push(13'h0123, 0); check("R7", 13'h0123, 1, 0, 0, 0);
    push(13'h1FFF, 0); check("R7 neg", 13'h1FFF, 1, 0, 0, 0);
    push(13'h07FF, 0); check("R7 top", 13'h07FF, 1, 0, 0, 0);
    push(13'h0800, 0); check("R8 over", 13'h07FF, 1, 1, 0, 0);
    push(13'h1700, 0); check("R8 under", 13'h1800, 1, 0, 1, 0);
  endtask

  task automatic t_orng;
    config_set(2'd0, 1'b0);
    push(13'h1800, 1); check("R9 full pos", 13'h0FFF, 1, 1, 0, 0);
    push(13'h0400, 1); check("R9 full neg", 13'h1000, 1, 0, 1, 0);
    config_set(2'd1, 1'b0);
    push(13'h1400, 1); check("R9 half pos", 13'h07FF, 1, 1, 0, 0);
    config_set(2'd2, 1'b1);
    push(13'h0123, 1); check("R9 reduced ignored", 13'h0123, 1, 0, 0, 0);
  endtask

  task automatic t_cfg;
    config_set(2'd2, 1'b0);
    check("R10 idle flag", 13'h0123, 0, 0, 0, 1);
    push(13'h0800, 0); check("R10 zero data", 13'h0000, 1, 0, 0, 1);
    config_set(2'd3, 1'b1);
    push(13'h0555, 0); check("R10 reserved", 13'h0000, 1, 0, 0, 1);
    config_set(2'd0, 1'b1);
    check("R10 cleared", 13'h0000, 0, 0, 0, 0);
  endtask

  task automatic t_hold;
    config_set(2'd0, 1'b1);
    push(13'h0042, 0); check("R2 load", 13'h0042, 1, 0, 0, 0);
    @(negedge clk); in_data = 13'h0FFF; in_orng = 1'b1;
    @(negedge clk); check("R2 hold", 13'h0042, 0, 0, 0, 0);
    in_orng = 1'b0;
  endtask

  initial begin
    t_reset();
    t_full();
    t_half();
    t_reduced();
    t_orng();
    t_cfg();
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule